// File: doc/BRIEF.md
# Serial Interface Engine Command Protocol Engine

This block sits between a host register bus and the internal state of a USB device core. The host never touches the device or endpoint state directly. It writes one 32-bit command-code word that names a phase and carries one byte. A command phase picks an operation. A following data-write phase supplies its operand, or a following data-read phase fetches its result into a command-data register. Each phase is consumed a fixed number of clocks after the write. Two sticky flags report the outcome: command-empty when a command or write phase has been consumed, and data-full when a read byte has arrived. The host clears both flags by writing ones to a clear register.

The engine holds a 7-bit device address with an enable bit, a configured bit, a connect bit, and a small bank of endpoint state. Each endpoint has a buffer-full bit, a stall bit and a disable bit. One endpoint is the selected one. The validate-buffer and clear-buffer operations act on it. USB line signalling, packet movement and interrupt routing belong to other blocks. The configuration outputs are plain level signals for those blocks.

The bus port is a plain single-cycle write strobe with a combinational read mux. There is no back-pressure: every bus write is taken in the cycle it is presented. A command-code write that arrives while a phase is still pending is dropped, so software must wait for the flag before it issues the next phase.

Top module: `sie_cmd_engine`

## Requirements
- R1: After reset both flags are 0, the device address, address-enable, configured and connect outputs are 0, and the command-data register reads 0.
- R2: A command-code write carries the phase in bits 15:8 and the byte in bits 23:16. The phase values are 0x05 (command), 0x01 (write data) and 0x02 (read data). Any other phase value is dropped, and neither flag nor any state changes.
- R3: Command-empty is bit 4 of the status register (bus address 0). It sets when a command or write phase is consumed. Writing a 1 to bit 4 of the clear register (bus address 1) clears it.
- R4: A phase written at clock edge k takes effect, and raises its flag, at edge k+4. A command-code write (bus address 2) made while a phase is pending is dropped.
- R5: Data-full is bit 5 of the status register, cleared by writing a 1 to bit 5 of the clear register. A read phase whose byte equals the last command code, and whose command has a result, loads the command-data register (bus address 3, bits 7:0) and sets data-full. Any other read phase is ignored: no flag is set and the data register is unchanged.
- R6: Command 0xD0 followed by a write loads the device address from data bits 6:0 and the address-enable from data bit 7.
- R7: Command 0xD8 followed by a write sets the configured output to data bit 0.
- R8: Command 0xFE followed by a write stores data bit 0 as the connect bit. Command 0xFE followed by a read returns the connect bit in bit 0, with all other bits 0.
- R9: Command 0x00+i, for i below the endpoint count, selects endpoint i. A matching read returns buffer-full in bits 0 and 5 and stall in bit 1, with all other bits 0.
- R10: Command 0x40+i followed by a write sets endpoint i's stall from data bit 0 and its disable from data bit 5. A data byte of 0 also empties the buffer. A disabled endpoint ignores validate-buffer.
- R11: A set-endpoint-status write with data bit 7 set, aimed at endpoint 0 or 1, stalls both endpoint 0 and endpoint 1 and leaves other endpoints unchanged.
- R12: Command 0xFA (validate-buffer) has no data phase. It marks the selected endpoint's buffer full.
- R13: Command 0xF2 followed by a read returns bit 0 = 1 if the selected buffer was full, with other bits 0. The same read empties that buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe, one cycle per write |
| bus_addr | input | 2 | Register select: 0 status, 1 clear, 2 command code, 3 command data |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Read data for the register chosen by bus_addr |
| cmd_empty | output | 1 | Command or write phase consumed (status bit 4) |
| data_full | output | 1 | Read byte available (status bit 5) |
| dev_addr | output | 7 | Programmed device address |
| dev_addr_en | output | 1 | Device address enable |
| dev_configured | output | 1 | Device configured |
| dev_connect | output | 1 | Connect request |

## Verification
On every cycle, the bound checker confirms three things. A flag rises only on the fourth edge after an accepted phase. A write-1 clear takes hold unless a completion coincides with it. The address, configuration, connect and command-data state change only on a completion edge. The bench scenarios cover the rest: what each command does to the endpoint bank, the way the selected endpoint carries across separate commands, the conditional stall of the two control endpoints, the dropped write during a pending phase, and the byte each read returns. A scoreboard matches every returned byte against the value predicted when the read was issued.

// File: rtl/sie_cmd_pkg.sv
package sie_cmd_pkg;
  // bus register map (word addresses)
  localparam logic [1:0] ADDR_STAT = 2'd0;
  localparam logic [1:0] ADDR_CLR  = 2'd1;
  localparam logic [1:0] ADDR_CODE = 2'd2;
  localparam logic [1:0] ADDR_DATA = 2'd3;

  // flag positions in status / clear registers
  localparam int FLG_EMPTY = 4;
  localparam int FLG_FULL  = 5;

  // phase encodings in bits 15:8 of the code word
  localparam logic [7:0] PH_CMD = 8'h05;
  localparam logic [7:0] PH_WR  = 8'h01;
  localparam logic [7:0] PH_RD  = 8'h02;

  // operation codes
  localparam logic [7:0] OP_SET_ADDR  = 8'hD0;
  localparam logic [7:0] OP_CONFIG    = 8'hD8;
  localparam logic [7:0] OP_DEV_STAT  = 8'hFE;
  localparam logic [7:0] OP_CLR_BUF   = 8'hF2;
  localparam logic [7:0] OP_VALID_BUF = 8'hFA;
  localparam logic [7:0] OP_SEL_BASE  = 8'h00;
  localparam logic [7:0] OP_EPST_BASE = 8'h40;

  typedef enum logic [1:0] {
    PK_NONE = 2'd0,
    PK_CMD  = 2'd1,
    PK_WR   = 2'd2,
    PK_RD   = 2'd3
  } phase_kind_e;

  typedef struct packed {
    logic full;
    logic stall;
    logic dis;
  } ep_state_t;

  function automatic phase_kind_e decode_phase(input logic [7:0] ph);
    case (ph)
      PH_CMD:  return PK_CMD;
      PH_WR:   return PK_WR;
      PH_RD:   return PK_RD;
      default: return PK_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sie_phase_timer.sv
module sie_phase_timer #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY + 1);
  localparam logic [CW-1:0] LOAD = CW'(DLY - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/sie_dev_regs.sv
module sie_dev_regs
  import sie_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_done,
  input  logic [7:0] last_cmd,
  input  logic [7:0] wbyte,
  output logic [6:0] dev_addr,
  output logic       dev_addr_en,
  output logic       dev_configured,
  output logic       dev_connect
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_addr       <= '0;
      dev_addr_en    <= 1'b0;
      dev_configured <= 1'b0;
      dev_connect    <= 1'b0;
    end else if (wr_done) begin
      case (last_cmd)
        OP_SET_ADDR: begin
          dev_addr    <= wbyte[6:0];
          dev_addr_en <= wbyte[7];
        end
        OP_CONFIG:   dev_configured <= wbyte[0];
        OP_DEV_STAT: dev_connect    <= wbyte[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/sie_ep_bank.sv
module sie_ep_bank
  import sie_cmd_pkg::*;
#(
  parameter int NUM_EP = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_done,
  input  logic       wr_done,
  input  logic       clrbuf_done,
  input  logic [7:0] cmd_code,
  input  logic [7:0] last_cmd,
  input  logic [7:0] wbyte,
  output logic [7:0] sel_status,
  output logic [7:0] clrbuf_status
);
  localparam int SW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1;
  localparam logic [7:0] EP_LIMIT = 8'(NUM_EP);

  logic [SW-1:0]     sel_q;
  logic [NUM_EP-1:0] full_v;
  logic [NUM_EP-1:0] stall_v;

  logic [7:0] sel_off;
  logic [7:0] epst_off;
  logic       sel_hit;
  logic       validate;
  logic       epst_hit;
  logic       cond_ctl;

  assign sel_off  = cmd_code - OP_SEL_BASE;
  assign epst_off = last_cmd - OP_EPST_BASE;
  assign sel_hit  = cmd_done && (sel_off < EP_LIMIT);
  assign validate = cmd_done && (cmd_code == OP_VALID_BUF);
  assign epst_hit = wr_done && (epst_off < EP_LIMIT);
  assign cond_ctl = epst_hit && wbyte[7] && (epst_off < 8'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sel_q <= '0;
    else if (sel_hit) sel_q <= sel_off[SW-1:0];
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    localparam bit IS_CTL = (i < 2);
    ep_state_t st_q;
    logic      tgt;
    logic      here;

    assign tgt  = epst_hit && (epst_off == 8'(i));
    assign here = (sel_q == SW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q <= '0;
      end else begin
        if (tgt) begin
          st_q.stall <= wbyte[0] | (wbyte[7] & IS_CTL);
          st_q.dis   <= wbyte[5];
          if (wbyte == 8'h00) st_q.full <= 1'b0;
        end else if (cond_ctl && IS_CTL) begin
          st_q.stall <= 1'b1;
        end
        if (validate && here && !st_q.dis) st_q.full <= 1'b1;
        else if (clrbuf_done && here)      st_q.full <= 1'b0;
      end
    end

    assign full_v[i]  = st_q.full;
    assign stall_v[i] = st_q.stall;
  end

  logic cur_full;
  logic cur_stall;
  assign cur_full  = full_v[sel_q];
  assign cur_stall = stall_v[sel_q];

  assign sel_status    = {1'b0, cur_full, 3'b000, cur_stall, cur_full};
  assign clrbuf_status = {7'b0, cur_full};
endmodule

// File: rtl/sie_cmd_engine.sv
module sie_cmd_engine
  import sie_cmd_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DLY    = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        cmd_empty,
  output logic        data_full,
  output logic [6:0]  dev_addr,
  output logic        dev_addr_en,
  output logic        dev_configured,
  output logic        dev_connect
);
  localparam logic [7:0] EP_LIMIT = 8'(NUM_EP);

  phase_kind_e in_kind;
  logic        accept;
  logic        busy;
  logic        done;

  phase_kind_e pend_kind;
  logic [7:0]  pend_byte;
  logic [7:0]  last_cmd;
  logic        cmd_seen;
  logic [7:0]  cmd_data_q;
  logic        empty_q;
  logic        full_q;

  assign in_kind = decode_phase(bus_wdata[15:8]);
  assign accept  = bus_wr && (bus_addr == ADDR_CODE) && !busy && (in_kind != PK_NONE);

  sie_phase_timer #(.DLY(DLY)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .start(accept),
    .busy (busy),
    .done (done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_kind <= PK_NONE;
      pend_byte <= '0;
    end else if (accept) begin
      pend_kind <= in_kind;
      pend_byte <= bus_wdata[23:16];
    end
  end

  logic cmd_done;
  logic wr_done;
  logic readable;
  logic rd_done;
  logic clrbuf_done;

  assign cmd_done = done && (pend_kind == PK_CMD);
  assign wr_done  = done && (pend_kind == PK_WR);
  assign readable = (pend_byte == OP_DEV_STAT) || (pend_byte == OP_CLR_BUF) ||
                    ((pend_byte - OP_SEL_BASE) < EP_LIMIT);
  assign rd_done  = done && (pend_kind == PK_RD) && cmd_seen &&
                    (pend_byte == last_cmd) && readable;
  assign clrbuf_done = rd_done && (pend_byte == OP_CLR_BUF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_cmd <= '0;
      cmd_seen <= 1'b0;
    end else if (cmd_done) begin
      last_cmd <= pend_byte;
      cmd_seen <= 1'b1;
    end
  end

  sie_dev_regs u_dev (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_done       (wr_done),
    .last_cmd      (last_cmd),
    .wbyte         (pend_byte),
    .dev_addr      (dev_addr),
    .dev_addr_en   (dev_addr_en),
    .dev_configured(dev_configured),
    .dev_connect   (dev_connect)
  );

  logic [7:0] sel_status;
  logic [7:0] clrbuf_status;

  sie_ep_bank #(.NUM_EP(NUM_EP)) u_eps (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_done     (cmd_done),
    .wr_done      (wr_done),
    .clrbuf_done  (clrbuf_done),
    .cmd_code     (pend_byte),
    .last_cmd     (last_cmd),
    .wbyte        (pend_byte),
    .sel_status   (sel_status),
    .clrbuf_status(clrbuf_status)
  );

  logic [7:0] rd_byte;
  always_comb begin
    case (pend_byte)
      OP_DEV_STAT: rd_byte = {7'b0, dev_connect};
      OP_CLR_BUF:  rd_byte = clrbuf_status;
      default:     rd_byte = sel_status;
    endcase
  end

  logic clr_wr;
  assign clr_wr = bus_wr && (bus_addr == ADDR_CLR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q    <= 1'b0;
      full_q     <= 1'b0;
      cmd_data_q <= '0;
    end else begin
      if (cmd_done || wr_done)             empty_q <= 1'b1;
      else if (clr_wr && bus_wdata[FLG_EMPTY]) empty_q <= 1'b0;
      if (rd_done)                         full_q  <= 1'b1;
      else if (clr_wr && bus_wdata[FLG_FULL])  full_q  <= 1'b0;
      if (rd_done) cmd_data_q <= rd_byte;
    end
  end

  assign cmd_empty = empty_q;
  assign data_full = full_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_STAT: begin
        bus_rdata[FLG_EMPTY] = empty_q;
        bus_rdata[FLG_FULL]  = full_q;
      end
      ADDR_DATA: bus_rdata[7:0] = cmd_data_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/sie_cmd_engine_chk.sv
module sie_cmd_engine_chk
  import sie_cmd_pkg::*;
#(
  parameter int DLY = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        cmd_empty,
  input logic        data_full,
  input logic [6:0]  dev_addr,
  input logic        dev_addr_en,
  input logic        dev_configured,
  input logic        dev_connect,
  input logic [7:0]  cmd_byte
);
  localparam int AW = $clog2(DLY + 2);
  localparam logic [AW-1:0] AGE_END = AW'(DLY);

  logic [AW-1:0] age_q;
  logic          done_q;
  logic          code_wr;

  assign code_wr = bus_wr && (bus_addr == ADDR_CODE) &&
                   ((bus_wdata[15:8] == PH_CMD) || (bus_wdata[15:8] == PH_WR) ||
                    (bus_wdata[15:8] == PH_RD));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (age_q == AGE_END);
      if (age_q != '0)  age_q <= (age_q == AGE_END) ? '0 : age_q + 1'b1;
      else if (code_wr) age_q <= AW'(1);
    end
  end

  // R4: a flag rises only on the completion edge of an accepted phase
  a_r4_flag_latency: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmd_empty) || $rose(data_full)) |-> done_q);

  // R3: a write-1 clear of command-empty holds unless a completion coincides
  a_r3_empty_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADDR_CLR && bus_wdata[FLG_EMPTY]) |=> (!cmd_empty || done_q));

  // R6: address state moves only on a completion edge
  a_r6_addr_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dev_addr) || !$stable(dev_addr_en)) |-> done_q);

  // R7: configured moves only on a completion edge
  a_r7_cfg_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_configured) |-> done_q);

  // R8: connect moves only on a completion edge
  a_r8_connect_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_connect) |-> done_q);

  // R5: the command-data byte changes only together with a read completion
  a_r5_data_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cmd_byte) |-> (done_q && data_full));
endmodule

bind sie_cmd_engine sie_cmd_engine_chk #(.DLY(DLY)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .cmd_empty     (cmd_empty),
  .data_full     (data_full),
  .dev_addr      (dev_addr),
  .dev_addr_en   (dev_addr_en),
  .dev_configured(dev_configured),
  .dev_connect   (dev_connect),
  .cmd_byte      (cmd_data_q)
);

// File: tb/sim_sie_cmd_engine.sv
module sim_sie_cmd_engine;
  import sie_cmd_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = ADDR_DATA;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmd_empty, data_full;
  logic [6:0]  dev_addr;
  logic        dev_addr_en, dev_configured, dev_connect;

  always #10 clk = ~clk;

  sie_cmd_engine u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmd_empty(cmd_empty),
    .data_full(data_full), .dev_addr(dev_addr), .dev_addr_en(dev_addr_en),
    .dev_configured(dev_configured), .dev_connect(dev_connect)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = ADDR_DATA;
  endtask

  task automatic send(input logic [7:0] ph, input logic [7:0] b);
    bus_write(ADDR_CODE, {8'h00, b, ph, 8'h00});
    repeat (5) @(negedge clk);
  endtask

  task automatic clear_flags();
    bus_write(ADDR_CLR, 32'h30);
  endtask

  task automatic do_cmd(input logic [7:0] b);
    send(PH_CMD, b); clear_flags();
  endtask

  task automatic do_wr(input logic [7:0] b);
    send(PH_WR, b); clear_flags();
  endtask

  // driver side of the scoreboard: predict, then issue the read phase
  task automatic do_rd(input logic [7:0] b, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    send(PH_RD, b); clear_flags();
  endtask

  // monitor side: every rising data-full pops one prediction
  initial begin
    logic       prev;
    logic [7:0] e;
    string      t;
    prev = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst_n) prev = 1'b0;
      else begin
        if (data_full && !prev) begin
          checks++;
          if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R5 unexpected read byte actual=%0h expected=none", bus_rdata[7:0]);
          end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata[7:0] !== e) begin
              fails++;
              $display("FAIL %s read byte actual=%0h expected=%0h", t, bus_rdata[7:0], e);
            end
          end
        end
        prev = data_full;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(cmd_empty == 0, "R1 cmd_empty", cmd_empty, 0);
    chk(data_full == 0, "R1 data_full", data_full, 0);
    chk({dev_addr_en, dev_addr} == 0, "R1 address", {dev_addr_en, dev_addr}, 0);
    chk(dev_configured == 0 && dev_connect == 0, "R1 cfg/connect",
        {dev_configured, dev_connect}, 0);
    chk(bus_rdata == 0, "R1 command data", bus_rdata, 0);

    // R4 latency: flag appears on the fourth edge after the write edge
    bus_write(ADDR_CODE, {8'h00, OP_SET_ADDR, PH_CMD, 8'h00});
    repeat (3) @(negedge clk);
    chk(cmd_empty == 0, "R4 flag before edge 4", cmd_empty, 0);
    @(negedge clk);
    chk(cmd_empty == 1, "R4 flag at edge 4", cmd_empty, 1);
    chk(data_full == 0, "R3 only empty flag", data_full, 0);
    bus_addr = ADDR_STAT;
    #1;
    chk(bus_rdata == 32'h10, "R3 status bit 4", bus_rdata, 32'h10);
    bus_addr = ADDR_DATA;
    bus_write(ADDR_CLR, 32'h10);
    chk(cmd_empty == 0, "R3 write-1 clear", cmd_empty, 0);
    do_wr(8'hAA);
    chk(dev_addr == 7'h2A && dev_addr_en == 1, "R6 address+enable",
        {dev_addr_en, dev_addr}, 8'hAA);
    do_cmd(OP_SET_ADDR); do_wr(8'h15);
    chk(dev_addr == 7'h15 && dev_addr_en == 0, "R6 enable clear",
        {dev_addr_en, dev_addr}, 8'h15);

    // R4 second code write while pending is dropped
    bus_write(ADDR_CODE, {8'h00, OP_CONFIG, PH_CMD, 8'h00});
    bus_write(ADDR_CODE, {8'h00, 8'h01, PH_WR, 8'h00});
    repeat (4) @(negedge clk);
    chk(dev_configured == 0, "R4 dropped write", dev_configured, 0);
    clear_flags();
    do_wr(8'h01);
    chk(dev_configured == 1, "R7 configure", dev_configured, 1);
    do_cmd(OP_CONFIG); do_wr(8'h00);
    chk(dev_configured == 0, "R7 unconfigure", dev_configured, 0);

    // R2 unknown phase value
    send(8'h07, OP_CONFIG);
    chk(cmd_empty == 0 && data_full == 0, "R2 bad phase flags", {data_full, cmd_empty}, 0);
    clear_flags();

    // R8 device status
    do_cmd(OP_DEV_STAT); do_wr(8'h01);
    chk(dev_connect == 1, "R8 connect", dev_connect, 1);
    do_cmd(OP_DEV_STAT); do_rd(OP_DEV_STAT, 8'h01, "R8 status read");
    do_cmd(OP_DEV_STAT); do_wr(8'hFE);
    chk(dev_connect == 0, "R8 disconnect", dev_connect, 0);
    do_cmd(OP_DEV_STAT); do_wr(8'hFF);
    do_cmd(OP_DEV_STAT); do_rd(OP_DEV_STAT, 8'h01, "R8 other bits zero");

    // R5 mismatched read is ignored
    do_cmd(OP_DEV_STAT);
    send(PH_RD, OP_CLR_BUF);
    chk(data_full == 0, "R5 mismatch no flag", data_full, 0);
    chk(bus_rdata[7:0] == 8'h01, "R5 mismatch data kept", bus_rdata[7:0], 8'h01);
    clear_flags();

    // R9 / R12 / R13 buffer handling on endpoint 2
    do_cmd(8'h02); do_rd(8'h02, 8'h00, "R9 empty endpoint");
    do_cmd(OP_VALID_BUF);
    do_cmd(8'h02); do_rd(8'h02, 8'h21, "R12 validated");
    do_cmd(OP_CLR_BUF); do_rd(OP_CLR_BUF, 8'h01, "R13 clear full");
    do_cmd(8'h02); do_rd(8'h02, 8'h00, "R13 emptied");
    do_cmd(OP_CLR_BUF); do_rd(OP_CLR_BUF, 8'h00, "R13 clear empty");

    // R10 stall and unstall on endpoint 3
    do_cmd(8'h43); do_wr(8'h01);
    do_cmd(8'h03); do_rd(8'h03, 8'h02, "R10 stalled");
    do_cmd(8'h43); do_wr(8'h00);
    do_cmd(8'h03); do_rd(8'h03, 8'h00, "R10 unstalled");

    // R10 disable and reinitialise on endpoint 2
    do_cmd(8'h42); do_wr(8'h20);
    do_cmd(8'h02); do_cmd(OP_VALID_BUF);
    do_cmd(8'h02); do_rd(8'h02, 8'h00, "R10 disabled ignores validate");
    do_cmd(8'h42); do_wr(8'h00);
    do_cmd(8'h02); do_cmd(OP_VALID_BUF);
    do_cmd(8'h02); do_rd(8'h02, 8'h21, "R10 enabled again");
    do_cmd(8'h42); do_wr(8'h00);
    do_cmd(8'h02); do_rd(8'h02, 8'h00, "R10 zero empties buffer");

    // R11 conditional stall of the control pair
    do_cmd(8'h40); do_wr(8'h80);
    do_cmd(8'h00); do_rd(8'h00, 8'h02, "R11 endpoint 0 stalled");
    do_cmd(8'h01); do_rd(8'h01, 8'h02, "R11 endpoint 1 stalled");
    do_cmd(8'h02); do_rd(8'h02, 8'h00, "R11 endpoint 2 untouched");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R5 every read returned", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule